// File: doc/BRIEF.md
# HI/LO Multiply-Accumulate Unit

This block multiplies two 32-bit operands and deposits the 64-bit outcome in a pair of 32-bit result registers, `hi` (upper half) and `lo` (lower half). Apart from a plain multiply, it can add the product to the 64-bit value already held in the pair, or subtract the product from it. Each of these three kinds comes in a signed form and an unsigned form.

A caller presents the operands and a 3-bit operation code, then pulses `start` for one cycle. The unit captures them, forms the product in the next cycle and updates the register pair in the cycle after that. A one-cycle `done` pulse appears together with the new `hi`/`lo` values. While an operation is in flight, further `start` pulses are dropped. The registers can be read at any time on the `hi` and `lo` ports.

Top module: `hilo_mac`

## Requirements
- R1: A synchronous active-high reset sets `hi` and `lo` to zero and holds `done` low.
- R2: The 64-bit result is split so that `hi` carries bits 63:32 and `lo` carries bits 31:0.
- R3: Operation code 0 (signed multiply) sign-extends both operands to 64 bits, multiplies them and writes the 64-bit product to the pair.
- R4: Operation code 1 (unsigned multiply) zero-extends both operands to 64 bits, multiplies them and writes the 64-bit product to the pair.
- R5: Operation codes 2 (signed) and 3 (unsigned) write back the 64-bit sum of the previous {hi,lo} value and the product.
- R6: Operation codes 4 (signed) and 5 (unsigned) write back the previous {hi,lo} value minus the product.
- R7: Accumulation and subtraction wrap modulo 2^64, and no flag is raised.
- R8: A start accepted at a clock edge leads to `hi`/`lo` updating and `done` rising together at the second edge after it. `done` stays high for exactly one cycle.
- R9: A `start` that arrives while an operation is in flight is ignored. It does not change that operation's result and it produces no later update or `done`.
- R10: Operation codes 6 and 7 leave `hi` and `lo` unchanged but still complete with a `done` pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Begin an operation when idle |
| opA | input | 32 | First operand |
| opB | input | 32 | Second operand |
| opCode | input | 3 | Bit 0 selects unsigned. Bits 2:1 select the kind: 00 multiply, 01 add, 10 subtract, 11 no change |
| hi | output | 32 | Upper half of the result pair |
| lo | output | 32 | Lower half of the result pair |
| done | output | 1 | One-cycle pulse when the pair has been written |

## Verification
Because each accumulating result feeds the next operation, a wrong value in the pair shows up on `hi`/`lo` as soon as `done` pulses. It then keeps propagating through every later multiply-add or multiply-subtract until a plain multiply overwrites it. A wrong sign choice shows up only for operands with the top bit set, which is why directed cases with 0x80000000 and all-ones operands sit beside the random traffic. A control state that fails to return to idle, or that accepts a start while busy, shows up within three cycles as a missing, extra or misplaced `done` pulse.

// File: rtl/mac_pkg.sv
package mac_pkg;

  typedef enum logic [1:0] {
    KIND_MUL  = 2'b00,
    KIND_ADD  = 2'b01,
    KIND_SUB  = 2'b10,
    KIND_HOLD = 2'b11
  } opKind_e;

  typedef struct packed {
    logic capture;
    logic mulEn;
    logic writeEn;
  } macStrobes_t;

endpackage

// File: rtl/mac_ctrl.sv
module mac_ctrl (
  input  logic                clk,
  input  logic                rst,
  input  logic                start,
  output mac_pkg::macStrobes_t strb,
  output logic                done
);
  typedef enum logic [1:0] {ST_IDLE, ST_MULT, ST_WRITE} ctrlState_e;
  ctrlState_e state;

  always_comb begin
    strb.capture = (state == ST_IDLE) && start;
    strb.mulEn   = (state == ST_MULT);
    strb.writeEn = (state == ST_WRITE);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_IDLE;
      done  <= 1'b0;
    end else begin
      done <= (state == ST_WRITE);
      case (state)
        ST_IDLE:  if (start) state <= ST_MULT;
        ST_MULT:  state <= ST_WRITE;
        ST_WRITE: state <= ST_IDLE;
        default:  state <= ST_IDLE;
      endcase
    end
  end

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst) done |=> !done); // R8
  AST_WRITE_DONE: assert property (@(posedge clk) disable iff (rst) strb.writeEn |=> done); // R8
  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (rst) $onehot0(strb)); // R9
  AST_BUSY_NO_CAPTURE: assert property (@(posedge clk) disable iff (rst)
    strb.capture |=> (!strb.capture && strb.mulEn)); // R9

endmodule

// File: rtl/mac_datapath.sv
module mac_datapath #(
  parameter int WIDTH = 32
) (
  input  logic                 clk,
  input  logic                 rst,
  input  mac_pkg::macStrobes_t strb,
  input  logic [WIDTH-1:0]     opA,
  input  logic [WIDTH-1:0]     opB,
  input  logic [2:0]           opCode,
  output logic [WIDTH-1:0]     hi,
  output logic [WIDTH-1:0]     lo
);
  localparam int DW = 2 * WIDTH;

  logic [WIDTH-1:0] aReg, bReg;
  logic             unsReg;
  mac_pkg::opKind_e kindReg;
  logic [DW-1:0]    prodReg;
  logic [DW-1:0]    extA, extB, product, pairNow, pairNext;

  always_comb begin
    extA    = unsReg ? {{WIDTH{1'b0}}, aReg} : {{WIDTH{aReg[WIDTH-1]}}, aReg};
    extB    = unsReg ? {{WIDTH{1'b0}}, bReg} : {{WIDTH{bReg[WIDTH-1]}}, bReg};
    product = extA * extB;
    pairNow = {hi, lo};
    case (kindReg)
      mac_pkg::KIND_MUL: pairNext = prodReg;
      mac_pkg::KIND_ADD: pairNext = pairNow + prodReg;
      mac_pkg::KIND_SUB: pairNext = pairNow - prodReg;
      default:           pairNext = pairNow;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      aReg    <= '0;
      bReg    <= '0;
      unsReg  <= 1'b0;
      kindReg <= mac_pkg::KIND_HOLD;
      prodReg <= '0;
      hi      <= '0;
      lo      <= '0;
    end else begin
      if (strb.capture) begin
        aReg    <= opA;
        bReg    <= opB;
        unsReg  <= opCode[0];
        kindReg <= mac_pkg::opKind_e'(opCode[2:1]);
      end
      if (strb.mulEn) prodReg <= product;
      if (strb.writeEn) {hi, lo} <= pairNext;
    end
  end

  AST_PAIR_QUIET: assert property (@(posedge clk) disable iff (rst)
    !strb.writeEn |=> ($stable(hi) && $stable(lo))); // R9
  AST_HOLD_CODE: assert property (@(posedge clk) disable iff (rst)
    (strb.writeEn && kindReg == mac_pkg::KIND_HOLD) |=> ($stable(hi) && $stable(lo))); // R10
  AST_OPERANDS_KEPT: assert property (@(posedge clk) disable iff (rst)
    (strb.mulEn || strb.writeEn) |=> ($stable(aReg) && $stable(bReg) && $stable(kindReg))); // R9

endmodule

// File: rtl/hilo_mac.sv
module hilo_mac #(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [WIDTH-1:0] opA,
  input  logic [WIDTH-1:0] opB,
  input  logic [2:0]       opCode,
  output logic [WIDTH-1:0] hi,
  output logic [WIDTH-1:0] lo,
  output logic             done
);
  mac_pkg::macStrobes_t strb;

  mac_ctrl uCtrl (
    .clk  (clk),
    .rst  (rst),
    .start(start),
    .strb (strb),
    .done (done)
  );

  mac_datapath #(.WIDTH(WIDTH)) uPath (
    .clk   (clk),
    .rst   (rst),
    .strb  (strb),
    .opA   (opA),
    .opB   (opB),
    .opCode(opCode),
    .hi    (hi),
    .lo    (lo)
  );

endmodule

// File: tb/tb_hilo_mac.sv
module tb_hilo_mac;
  logic        clk = 1'b0;
  logic        rst;
  logic        start;
  logic [31:0] opA, opB;
  logic [2:0]  opCode;
  logic [31:0] hi, lo;
  logic        done;

  int checks = 0;
  int fails  = 0;
  logic [63:0] model = '0;

  always #5 clk = ~clk;

  hilo_mac dut (
    .clk(clk), .rst(rst), .start(start), .opA(opA), .opB(opB),
    .opCode(opCode), .hi(hi), .lo(lo), .done(done)
  );

  function automatic logic [63:0] expect_pair(logic [63:0] prev, logic [2:0] code,
                                              logic [31:0] a, logic [31:0] b);
    logic [63:0] ea, eb, p;
    ea = code[0] ? {32'd0, a} : {{32{a[31]}}, a};
    eb = code[0] ? {32'd0, b} : {{32{b[31]}}, b};
    p  = ea * eb;
    case (code[2:1])
      2'b00:   return p;
      2'b01:   return prev + p;
      2'b10:   return prev - p;
      default: return prev;
    endcase
  endfunction

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Issue one operation, check done timing and result; optionally hold start while busy.
  task automatic run_op(input logic [2:0] code, input logic [31:0] a, input logic [31:0] b,
                        input bit holdBusy, input string req);
    logic [63:0] exp;
    exp = expect_pair(model, code, a, b);
    @(negedge clk);
    start = 1'b1; opA = a; opB = b; opCode = code;
    @(negedge clk);
    if (holdBusy) begin
      opA = ~a; opB = b + 32'd7; opCode = 3'd2;
    end else start = 1'b0;
    check(done == 1'b0, "R8 early done", {63'd0, done}, 64'd0);
    @(negedge clk);
    check(done == 1'b0, "R8 early done", {63'd0, done}, 64'd0);
    @(negedge clk);
    start = 1'b0;
    check(done == 1'b1, "R8 done at second edge", {63'd0, done}, 64'd1);
    check({hi, lo} == exp, req, {hi, lo}, exp);
    model = exp;
    @(negedge clk);
    check(done == 1'b0, "R8 done one cycle", {63'd0, done}, 64'd0);
    if (holdBusy) begin
      for (int i = 0; i < 4; i++) begin
        check(done == 1'b0, "R9 no extra done", {63'd0, done}, 64'd0);
        check({hi, lo} == model, "R9 pair unchanged", {hi, lo}, model);
        @(negedge clk);
      end
    end
  endtask

  initial begin
    #(200000 * 10);
    checks++; fails++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    logic [31:0] ra, rb;
    logic [2:0]  rc;
    void'($urandom(32'd20240611));
    rst = 1'b1; start = 1'b0; opA = '0; opB = '0; opCode = '0;
    repeat (3) @(negedge clk);
    // R1: pair and done cleared by reset
    check({hi, lo} == 64'd0, "R1 pair reset", {hi, lo}, 64'd0);
    check(done == 1'b0, "R1 done reset", {63'd0, done}, 64'd0);
    rst = 1'b0;

    run_op(3'd0, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b0, "R3 signed -1*-1");
    run_op(3'd0, 32'h8000_0000, 32'h8000_0000, 1'b0, "R3 signed min*min");
    check(hi == 32'h4000_0000 && lo == 32'd0, "R2 halves", {hi, lo}, 64'h4000_0000_0000_0000);
    run_op(3'd1, 32'h8000_0000, 32'h8000_0000, 1'b0, "R4 unsigned top*top");
    run_op(3'd1, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b0, "R4 unsigned max*max");
    run_op(3'd0, 32'h1234_5678, 32'hFFFF_FFFE, 1'b0, "R3 signed mixed");
    run_op(3'd2, 32'h7FFF_FFFF, 32'h8000_0000, 1'b0, "R5 signed add");
    run_op(3'd3, 32'hFFFF_FFFF, 32'h0000_0002, 1'b0, "R5 unsigned add");
    run_op(3'd4, 32'hFFFF_FFFF, 32'h0000_0003, 1'b0, "R6 signed sub");
    run_op(3'd5, 32'hFFFF_FFFF, 32'h0000_0003, 1'b0, "R6 unsigned sub");
    // R7: wrap around in both directions
    run_op(3'd0, 32'hFFFF_FFFF, 32'h0000_0001, 1'b0, "R3 all ones setup");
    run_op(3'd3, 32'h0000_0001, 32'h0000_0001, 1'b0, "R7 add wraps to zero");
    check({hi, lo} == 64'd0, "R7 add wrap value", {hi, lo}, 64'd0);
    run_op(3'd5, 32'h0000_0001, 32'h0000_0001, 1'b0, "R7 sub wraps");
    check({hi, lo} == 64'hFFFF_FFFF_FFFF_FFFF, "R7 sub wrap value", {hi, lo}, 64'hFFFF_FFFF_FFFF_FFFF);
    // R10: no-change codes
    run_op(3'd6, 32'h0000_0005, 32'h0000_0007, 1'b0, "R10 code 6 holds");
    run_op(3'd7, 32'hDEAD_BEEF, 32'h0000_0009, 1'b0, "R10 code 7 holds");
    // R9: start held high while busy
    run_op(3'd1, 32'h0001_0000, 32'h0001_0000, 1'b1, "R9 busy start ignored");

    for (int n = 0; n < 300; n++) begin
      ra = $urandom; rb = $urandom; rc = 3'($urandom_range(0, 5));
      if (n % 17 == 0) ra = 32'h8000_0000;
      if (n % 23 == 0) rb = 32'hFFFF_FFFF;
      run_op(rc, ra, rb, 1'b0, "R5 R6 random sequence");
    end

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule